// File: doc/BRIEF.md
# Streaming Block Protection Tuple Checker

The block verifies the 8-byte protection tuple that travels with every logical block of a multi-block transfer. A command is presented for one cycle. It carries the enable bits, the protection type, where the tuple sits inside the metadata, the expected application tag and mask, the starting expected reference tag, the starting LBA and a zero-based block count. The transfer then arrives one byte per accepted cycle. The data bytes of each block come first, then its metadata. The block computes the guard CRC over the protected extent and captures the stored tuple. At the end of every block it compares the tuple against the expected values.

The command finishes with a single `done` pulse and a result code. The code is success, or the first error seen: guard, application tag, reference tag, or an invalid-protection-information rejection raised before any data is accepted. Stored tags of all ones act as escape values that switch checking off for one block. The escape rule depends on the protection type.

Top module: `pi_tuple_checker`

## Requirements
- R1: After reset `done` is 0 and `status` is 0.
- R2: A command with `cmd_ptype` = 1 whose `cmd_slba[31:0]` differs from `cmd_ref_tag` ends one cycle later with `done` = 1 and `status` = 4, accepts no data, and leaves the block ready for a new command. Upper LBA bits are not compared. Types 2 and 3 skip this comparison.
- R3: The guard check is enabled by `cmd_ctrl[12]`. The guard is a CRC-16 with polynomial 0x8BB7, initial value 0, MSB first and no final inversion. A mismatch gives status 1.
- R4: The application tag check is enabled by `cmd_ctrl[11]`. It compares the stored tag and `cmd_app_tag`, each ANDed with `cmd_app_mask`, so bits outside the mask never cause an error. A mismatch gives status 2.
- R5: The reference tag check is enabled by `cmd_ctrl[10]`. A mismatch gives status 3. For types 1 and 2 the expected tag of block k is `cmd_ref_tag` + k. For type 3 it stays `cmd_ref_tag` for every block.
- R6: Checks run in the order guard, application tag, reference tag. The first failing block ends the command with exactly one `done`, and the rest of that transfer is ignored.
- R7: For types 1 and 2, a block whose stored application tag is 0xFFFF passes no matter what its other fields hold.
- R8: For type 3, a block passes unchecked only when the stored application tag is 0xFFFF and the stored reference tag is 0xFFFFFFFF. Either value on its own does not escape.
- R9: Tuple layout is guard, then application tag, then reference tag, each big-endian. With `cmd_tuple_first` = 0 the tuple is the last 8 metadata bytes and the guard covers the data plus the metadata before the tuple. With `cmd_tuple_first` = 1 the tuple is the first 8 metadata bytes and the guard covers the data only.
- R10: `cmd_nlb` is the block count minus one. `done` is a one-cycle pulse in the cycle after the last byte of the deciding block is accepted. `status` 0 means every block passed.
- R11: `cmd_valid` is ignored while a command is in progress. `in_valid` is ignored while no command is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_ctrl | input | 16 | Command control word; bits 12..10 enable guard, application and reference checks |
| cmd_ptype | input | 3 | Protection type (1, 2 or 3) |
| cmd_tuple_first | input | 1 | 1: tuple is the first 8 metadata bytes; 0: the last 8 |
| cmd_app_tag | input | 16 | Expected application tag |
| cmd_app_mask | input | 16 | Application tag compare mask |
| cmd_ref_tag | input | 32 | Expected reference tag of the first block |
| cmd_slba | input | 64 | Starting LBA |
| cmd_nlb | input | NLB_W | Number of blocks minus one |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Transfer byte |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Result: 0 ok, 1 guard, 2 app tag, 3 ref tag, 4 invalid protection info |

## Verification
Several conditions are hard to reach from the ports. One is a block in the middle of a transfer that holds more than one fault at once. Another is a type-3 block that carries only half of the escape pattern. A third is a tuple placed so that trailing metadata falls outside the guard extent. The bench builds every block arithmetically and corrupts a chosen field of the middle block of a three-block command. It sweeps all enable combinations, all three types, both tuple positions and nine corruption patterns, so the first-error priority and the escape rules are tested against every mask of enables. Stalled byte cycles and a stray command strobe in the middle of the stream are mixed in, so that the completion cycle and the ignore rules are exercised under irregular input.

// File: rtl/pi_chk_pkg.sv
package pi_chk_pkg;

   typedef enum logic [2:0] {
      ST_OK    = 3'd0,
      ST_GUARD = 3'd1,
      ST_APP   = 3'd2,
      ST_REF   = 3'd3,
      ST_BADPI = 3'd4
   } pi_status_e;

   localparam int unsigned TUPLE_BYTES = 8;
   localparam int unsigned EN_GUARD    = 12;
   localparam int unsigned EN_APP      = 11;
   localparam int unsigned EN_REF      = 10;
   localparam logic [15:0] GUARD_POLY  = 16'h8BB7;

   // stored tuple, first byte on the wire lands in the top bits
   typedef struct packed {
      logic [15:0] guard;
      logic [15:0] app;
      logic [31:0] ref_tag;
   } pi_tuple_t;

   function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r;
      r = c ^ {b, 8'h00};
      for (int k = 0; k < 8; k++) begin
         r = r[15] ? ((r << 1) ^ GUARD_POLY) : (r << 1);
      end
      return r;
   endfunction

endpackage

// File: rtl/pi_byte_pos.sv
module pi_byte_pos
   import pi_chk_pkg::*;
#(
   parameter int unsigned DATA_BYTES = 512,
   parameter int unsigned META_BYTES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   input  logic tuple_first,
   output logic in_crc,
   output logic in_tuple,
   output logic last
);
   localparam int unsigned BLK   = DATA_BYTES + META_BYTES;
   localparam int unsigned POS_W = $clog2(BLK);

   logic [POS_W-1:0] pos_q;
   logic [POS_W-1:0] toff;

   generate
      if (META_BYTES == TUPLE_BYTES) begin : g_fixed
         // tuple fills the metadata: both placements coincide
         logic unused_sel;
         assign unused_sel = tuple_first;
         assign toff = POS_W'(DATA_BYTES);
      end else begin : g_select
         assign toff = tuple_first ? POS_W'(DATA_BYTES) : POS_W'(BLK - TUPLE_BYTES);
      end
   endgenerate

   assign in_crc   = pos_q < toff;
   assign in_tuple = ({1'b0, pos_q} >= {1'b0, toff}) &&
                     ({1'b0, pos_q} < ({1'b0, toff} + (POS_W+1)'(TUPLE_BYTES)));
   assign last     = pos_q == POS_W'(BLK - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pos_q <= '0;
      else if (clr)    pos_q <= '0;
      else if (adv)    pos_q <= last ? '0 : pos_q + 1'b1;
   end
endmodule

// File: rtl/pi_guard_crc.sv
module pi_guard_crc
   import pi_chk_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        restart,
   input  logic        en,
   input  logic [7:0]  din,
   output logic [15:0] crc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       crc <= '0;
      else if (restart) crc <= '0;
      else if (en)      crc <= crc_step(crc, din);
   end
endmodule

// File: rtl/pi_tuple_capture.sv
module pi_tuple_capture
   import pi_chk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       shift_en,
   input  logic [7:0] din,
   output pi_tuple_t  tup_nxt
);
   logic [63:0] sh_q;

   assign tup_nxt = shift_en ? pi_tuple_t'({sh_q[55:0], din}) : pi_tuple_t'(sh_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sh_q <= '0;
      else if (shift_en) sh_q <= {sh_q[55:0], din};
   end
endmodule

// File: rtl/pi_verdict.sv
module pi_verdict
   import pi_chk_pkg::*;
(
   input  pi_tuple_t   tup,
   input  logic [15:0] crc,
   input  logic [2:0]  en,      // {guard, app, ref}
   input  logic [2:0]  ptype,
   input  logic [15:0] exp_app,
   input  logic [15:0] app_mask,
   input  logic [31:0] exp_ref,
   output pi_status_e  verdict
);
   logic app_ones, ref_ones, skip;

   assign app_ones = tup.app == 16'hFFFF;
   assign ref_ones = tup.ref_tag == 32'hFFFF_FFFF;
   assign skip     = ((ptype == 3'd1 || ptype == 3'd2) && app_ones) ||
                     (ptype == 3'd3 && app_ones && ref_ones);

   always_comb begin
      verdict = ST_OK;
      if (!skip) begin
         if (en[2] && tup.guard != crc)
            verdict = ST_GUARD;
         else if (en[1] && ((tup.app & app_mask) != (exp_app & app_mask)))
            verdict = ST_APP;
         else if (en[0] && tup.ref_tag != exp_ref)
            verdict = ST_REF;
      end
   end
endmodule

// File: rtl/pi_tuple_checker.sv
module pi_tuple_checker
   import pi_chk_pkg::*;
#(
   parameter int unsigned DATA_BYTES = 512,
   parameter int unsigned META_BYTES = 8,
   parameter int unsigned NLB_W      = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [15:0]      cmd_ctrl,
   input  logic [2:0]       cmd_ptype,
   input  logic             cmd_tuple_first,
   input  logic [15:0]      cmd_app_tag,
   input  logic [15:0]      cmd_app_mask,
   input  logic [31:0]      cmd_ref_tag,
   input  logic [63:0]      cmd_slba,
   input  logic [NLB_W-1:0] cmd_nlb,
   input  logic             in_valid,
   input  logic [7:0]       in_byte,
   output logic             done,
   output logic [2:0]       status
);
   generate
      if (META_BYTES < TUPLE_BYTES) begin : g_bad_meta
         $error("META_BYTES must hold the 8-byte tuple");
      end
      if (DATA_BYTES < 1) begin : g_bad_data
         $error("DATA_BYTES must be at least 1");
      end
      if (NLB_W < 1 || NLB_W > 32) begin : g_bad_nlb
         $error("NLB_W out of range");
      end
   endgenerate

   logic             busy_q, done_q, tfirst_q;
   logic [2:0]       en_q, ptype_q;
   logic [15:0]      app_q, mask_q;
   logic [31:0]      ref_q;
   logic [NLB_W-1:0] left_q;
   pi_status_e       status_q;

   logic       start, badpi, adv, blk_end, fail;
   logic       in_crc, in_tuple, last;
   logic [15:0] crc;
   pi_tuple_t  tup_nxt;
   pi_status_e verdict;

   logic [12:0] unused_ctrl;
   logic [31:0] unused_slba;
   assign unused_ctrl = {cmd_ctrl[15:13], cmd_ctrl[9:0]};
   assign unused_slba = cmd_slba[63:32];

   assign start   = cmd_valid && !busy_q;
   assign badpi   = (cmd_ptype == 3'd1) && (cmd_slba[31:0] != cmd_ref_tag);
   assign adv     = busy_q && in_valid;
   assign blk_end = adv && last;
   assign fail    = blk_end && (verdict != ST_OK);

   pi_byte_pos #(.DATA_BYTES(DATA_BYTES), .META_BYTES(META_BYTES)) u_pos (
      .clk(clk), .rst_n(rst_n), .clr(start), .adv(adv), .tuple_first(tfirst_q),
      .in_crc(in_crc), .in_tuple(in_tuple), .last(last)
   );

   pi_guard_crc u_crc (
      .clk(clk), .rst_n(rst_n), .restart(start || blk_end),
      .en(adv && in_crc), .din(in_byte), .crc(crc)
   );

   pi_tuple_capture u_cap (
      .clk(clk), .rst_n(rst_n), .shift_en(adv && in_tuple),
      .din(in_byte), .tup_nxt(tup_nxt)
   );

   pi_verdict u_verdict (
      .tup(tup_nxt), .crc(crc), .en(en_q), .ptype(ptype_q),
      .exp_app(app_q), .app_mask(mask_q), .exp_ref(ref_q), .verdict(verdict)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         tfirst_q <= 1'b0;
         en_q     <= '0;
         ptype_q  <= '0;
         app_q    <= '0;
         mask_q   <= '0;
         ref_q    <= '0;
         left_q   <= '0;
         status_q <= ST_OK;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            en_q     <= {cmd_ctrl[EN_GUARD], cmd_ctrl[EN_APP], cmd_ctrl[EN_REF]};
            ptype_q  <= cmd_ptype;
            tfirst_q <= cmd_tuple_first;
            app_q    <= cmd_app_tag;
            mask_q   <= cmd_app_mask;
            ref_q    <= cmd_ref_tag;
            left_q   <= cmd_nlb;
            if (badpi) begin
               done_q   <= 1'b1;
               status_q <= ST_BADPI;
            end else begin
               busy_q   <= 1'b1;
               status_q <= ST_OK;
            end
         end else if (blk_end) begin
            if (fail) begin
               busy_q   <= 1'b0;
               done_q   <= 1'b1;
               status_q <= verdict;
            end else begin
               if (ptype_q != 3'd3) ref_q <= ref_q + 32'd1;
               if (left_q == '0) begin
                  busy_q   <= 1'b0;
                  done_q   <= 1'b1;
                  status_q <= ST_OK;
               end else begin
                  left_q <= left_q - 1'b1;
               end
            end
         end
      end
   end

   assign done   = done_q;
   assign status = status_q;
endmodule

// File: rtl/pi_tuple_checker_chk.sv
module pi_tuple_checker_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_valid,
   input logic [2:0]  cmd_ptype,
   input logic [31:0] cmd_slba_lo,
   input logic [31:0] cmd_ref_tag,
   input logic        done,
   input logic [2:0]  status,
   input logic        busy,
   input logic [2:0]  ptype_q,
   input logic [31:0] ref_q,
   input logic        blk_end,
   input logic        fail
);
   p_badpi_reply_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_valid && cmd_ptype == 3'd1 && cmd_slba_lo != cmd_ref_tag)
      |=> (done && status == 3'd4 && !busy));

   p_type3_ref_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && ptype_q == 3'd3) |-> $stable(ref_q));

   p_ref_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_end && !fail && ptype_q != 3'd3) |=> (ref_q == $past(ref_q) + 32'd1));

   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !blk_end) |=> busy);
endmodule

bind pi_tuple_checker pi_tuple_checker_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ptype(cmd_ptype),
   .cmd_slba_lo(cmd_slba[31:0]), .cmd_ref_tag(cmd_ref_tag),
   .done(done), .status(status), .busy(busy_q), .ptype_q(ptype_q),
   .ref_q(ref_q), .blk_end(blk_end), .fail(fail)
);

// File: tb/pi_tuple_checker_tb.sv
module pi_tuple_checker_tb;
   localparam int DW = 8, MW = 16, BLK = DW + MW, NW = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [15:0]   cmd_ctrl = '0;
   logic [2:0]    cmd_ptype = '0;
   logic          cmd_tuple_first = 1'b0;
   logic [15:0]   cmd_app_tag = '0, cmd_app_mask = '0;
   logic [31:0]   cmd_ref_tag = '0;
   logic [63:0]   cmd_slba = '0;
   logic [NW-1:0] cmd_nlb = '0;
   logic          in_valid = 1'b0;
   logic [7:0]    in_byte = '0;
   logic          done;
   logic [2:0]    status;

   pi_tuple_checker #(.DATA_BYTES(DW), .META_BYTES(MW), .NLB_W(NW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ctrl(cmd_ctrl),
      .cmd_ptype(cmd_ptype), .cmd_tuple_first(cmd_tuple_first),
      .cmd_app_tag(cmd_app_tag), .cmd_app_mask(cmd_app_mask),
      .cmd_ref_tag(cmd_ref_tag), .cmd_slba(cmd_slba), .cmd_nlb(cmd_nlb),
      .in_valid(in_valid), .in_byte(in_byte), .done(done), .status(status)
   );

   int n_vec = 0, n_bad = 0;
   int cyc = 0, done_cnt = 0, done_cyc = 0;
   logic [2:0] done_st = '0;

   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) if (done) begin done_cnt++; done_cyc = cyc; done_st = status; end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish (actual hung, expected completion)");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   task automatic check(input string req, input int got, input int exp);
      n_vec++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, got, exp);
      end
   endtask

   // independent bitwise model of the guard CRC
   function automatic logic [15:0] crc_bytes(input logic [7:0] b [], input int from, input int n);
      logic [15:0] c = 16'h0;
      for (int i = 0; i < n; i++)
         for (int k = 7; k >= 0; k--) begin
            logic fb;
            fb = c[15] ^ b[from + i][k];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h8BB7;
         end
      return c;
   endfunction

   function automatic string tag_of(input int kind, input int pt, input int st, input int tf);
      if (kind == 4 || kind == 6 || kind == 8) return (pt == 3) ? "R8" : "R7";
      if (kind == 7) return "R6";
      if (kind == 5) return "R4";
      if (st == 1) return "R3";
      if (st == 2) return "R4";
      if (st == 3) return "R5";
      return tf ? "R9" : "R10";
   endfunction

   task automatic run_cmd(input logic [2:0] en, input int pt, input logic tf,
                          input logic [31:0] rt, input logic [63:0] sl, input int nb,
                          input int kind, input int inj, input int seed, input logic mid);
      logic [7:0]  b [] = new[nb * BLK];
      logic [15:0] app = 16'h3C5A ^ 16'(seed * 77);
      logic [15:0] mask = 16'hFF0F;
      int toff = tf ? DW : BLK - 8;
      int exp_st = 0, exp_blk = nb - 1, exp_cyc = -1, cnt0;
      for (int blk = 0; blk < nb; blk++) begin
         int base = blk * BLK;
         logic [31:0] eref = (pt == 3) ? rt : rt + 32'(blk);
         logic [15:0] g, a;
         logic [31:0] r;
         logic skip;
         for (int i = 0; i < BLK; i++) b[base + i] = 8'((seed * 29 + (base + i) * 13 + 7));
         g = crc_bytes(b, base, toff);
         a = app; r = eref;
         if (blk == inj) begin
            case (kind)
               1: g ^= 16'h0001;
               2: a ^= 16'h0001;
               3: r ^= 32'h0000_0100;
               4: begin a = 16'hFFFF; r = 32'hFFFF_FFFF; g ^= 16'h1; end
               5: a ^= 16'h0010;
               6: begin a = 16'hFFFF; g ^= 16'h1; end
               7: begin g ^= 16'h1; a ^= 16'h1; r ^= 32'h1; end
               8: begin r = 32'hFFFF_FFFF; g ^= 16'h1; end
               default: ;
            endcase
         end
         {b[base+toff], b[base+toff+1]} = g;
         {b[base+toff+2], b[base+toff+3]} = a;
         {b[base+toff+4], b[base+toff+5], b[base+toff+6], b[base+toff+7]} = r;
         skip = ((pt == 1 || pt == 2) && a == 16'hFFFF) ||
                (pt == 3 && a == 16'hFFFF && r == 32'hFFFF_FFFF);
         if (exp_st == 0 && !skip) begin
            if (en[2] && g != crc_bytes(b, base, toff)) exp_st = 1;
            else if (en[1] && (a & mask) != (app & mask)) exp_st = 2;
            else if (en[0] && r != eref) exp_st = 3;
            if (exp_st != 0) exp_blk = blk;
         end
      end
      @(negedge clk);
      cnt0 = done_cnt;
      cmd_valid = 1'b1; cmd_ctrl = {3'b0, en, 10'h2A5}; cmd_ptype = 3'(pt);
      cmd_tuple_first = tf; cmd_app_tag = app; cmd_app_mask = mask;
      cmd_ref_tag = rt; cmd_slba = sl; cmd_nlb = NW'(nb - 1);
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int i = 0; i < nb * BLK; i++) begin
         if (i % 7 == 3) begin in_valid = 1'b0; @(negedge clk); end
         in_valid = 1'b1; in_byte = b[i];
         if (mid && i == 5) begin   // stray command while busy (R11)
            cmd_valid = 1'b1; cmd_ptype = 3'd1; cmd_slba = 64'h5; cmd_ref_tag = 32'h9;
         end
         @(negedge clk);
         cmd_valid = 1'b0;
         if (i == (exp_blk + 1) * BLK - 1) exp_cyc = cyc;
      end
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      check("R6 single done", done_cnt - cnt0, 1);
      check(tag_of(kind, pt, exp_st, int'(tf)), int'(done_st), exp_st);
      check("R10 done cycle", done_cyc, exp_cyc);
   endtask

   initial begin
      logic [7:0] kat [] = new[9];
      int c0;
      for (int i = 0; i < 9; i++) kat[i] = 8'h31 + 8'(i);
      check("R3 crc known answer", int'(crc_bytes(kat, 0, 9)), 16'hD0DB);

      repeat (3) @(negedge clk);
      check("R1 done at reset", int'(done), 0);
      check("R1 status at reset", int'(status), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: type-1 LBA/ref mismatch rejected without data
      cmd_valid = 1'b1; cmd_ptype = 3'd1; cmd_ctrl = 16'h1C00;
      cmd_slba = 64'h0000_0000_0000_0010; cmd_ref_tag = 32'h11; cmd_nlb = '0;
      @(negedge clk);
      cmd_valid = 1'b0;
      check("R2 reject done", int'(done), 1);
      check("R2 reject status", int'(status), 4);
      @(negedge clk);
      check("R2 single pulse", int'(done), 0);
      run_cmd(3'b111, 1, 1'b0, 32'h1234, {32'h0000_00A5, 32'h1234}, 2, 0, 0, 1, 1'b0); // R2 upper bits ignored
      run_cmd(3'b111, 2, 1'b0, 32'h77, 64'h5, 1, 0, 0, 2, 1'b0);                       // R2 type 2 skips precheck
      run_cmd(3'b111, 3, 1'b1, 32'h77, 64'h5, 1, 0, 0, 3, 1'b0);                       // R2 type 3 skips precheck

      // R11: bytes while idle are ignored
      c0 = done_cnt;
      for (int i = 0; i < 40; i++) begin in_valid = 1'b1; in_byte = 8'(i * 5); @(negedge clk); end
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      check("R11 idle bytes", done_cnt - c0, 0);
      run_cmd(3'b111, 1, 1'b1, 32'hFFFF_FFFE, {32'h0, 32'hFFFF_FFFE}, 4, 0, 9, 4, 1'b1);

      // sweep
      for (int pt = 1; pt <= 3; pt++)
         for (int en = 0; en < 8; en++)
            for (int tf = 0; tf < 2; tf++)
               for (int kind = 0; kind < 9; kind++) begin
                  int seed = pt * 1000 + en * 100 + tf * 10 + kind;
                  logic [31:0] rt = 32'h0001_FFFE + 32'(seed);
                  run_cmd(3'(en), pt, 1'(tf), rt, {32'h0000_00A5, rt}, 3, kind, 1,
                          seed, 1'((seed % 2) == 0));
               end

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule